// File: doc/BRIEF.md
# Message Channel Transmit Path with Loopback

This block sits between a local message channel and a shared bus line. Local transmit data can reach the bus either directly, in the same cycle, or through a register that captures it on each rising edge of the channel clock. Two control bits in an 8-bit configuration byte choose the behaviour. Both bits can be read back.

A second control bit isolates the block from the bus. When it is set, the bus driver is switched off and the transmit value is fed back into the local receive output. The local channel can then be exercised without disturbing other agents on the shared line. The value fed back is taken after the choice between the direct and the registered path, so both transmit modes can be tested in isolation. The bus driver is modelled as a data value plus an output enable, not as a tri-state net.

Top module: `msgch_txpath`

## Requirements
- R1: After the asynchronous reset, both control bits are 0, `cfg_rdata_o` reads 0, `bus_oe_o` is 1 and the transmit path is in pass-through mode.
- R2: While control bit 4 is 0, `bus_data_o` equals `tx_data_i` in the same cycle.
- R3: While control bit 4 is 1, `bus_data_o` equals the value `tx_data_i` had at the most recent rising clock edge.
- R4: `bus_oe_o` is 1 while control bit 5 is 0, and 0 while it is 1.
- R5: While control bit 5 is 1, `rx_data_o` equals `bus_data_o`, so the value looped back follows the transmit mode selected by bit 4.
- R6: While control bit 5 is 0, `rx_data_o` equals `bus_data_i`.
- R7: A rising edge with `cfg_we_i` high stores bits 5 and 4 of `cfg_wdata_i`. A rising edge with `cfg_we_i` low leaves the stored bits unchanged. `cfg_rdata_o` returns the stored bits at positions 5 and 4 and 0 in every other position.
- R8: While control bit 5 is 1, `bus_data_i` has no effect on `rx_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration readback |
| tx_data_i | input | DATA_W | Local transmit data |
| bus_data_o | output | DATA_W | Data presented to the bus line |
| bus_oe_o | output | 1 | Bus driver enable |
| bus_data_i | input | DATA_W | Data sampled from the bus line |
| rx_data_o | output | DATA_W | Local receive data |

## Verification
Two things can happen on the same rising edge: a configuration write that changes the mode bits, and the transmit register capturing new data. The bench provokes this with frequent random writes while `tx_data_i` changes every cycle. It checks the cycle after each write and expects the newly selected path to show the data captured at that same edge. Loopback is toggled in the same way while `bus_data_i` is driven with values unrelated to the transmit data. Every output is compared with the bench model after each edge.

// File: rtl/msgch_pkg.sv
package msgch_pkg;
  localparam int unsigned CFG_W    = 8;
  localparam int unsigned MODE_BIT = 4;  // 1: registered transmit
  localparam int unsigned LOOP_BIT = 5;  // 1: bus released, loopback

  typedef struct packed {
    logic loop;
    logic reg_mode;
  } msgch_ctrl_t;
endpackage

// File: rtl/msgch_cfg_reg.sv
module msgch_cfg_reg
  import msgch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output msgch_ctrl_t      ctrl_o
);
  msgch_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.loop     <= wdata_i[LOOP_BIT];
      ctrl_q.reg_mode <= wdata_i[MODE_BIT];
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[LOOP_BIT] = ctrl_q.loop;
    rdata_o[MODE_BIT] = ctrl_q.reg_mode;
  end

  assign ctrl_o = ctrl_q;

  p_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[LOOP_BIT] == $past(wdata_i[LOOP_BIT]) &&
              rdata_o[MODE_BIT] == $past(wdata_i[MODE_BIT])));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/msgch_tx_stage.sv
module msgch_tx_stage #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_reg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;
  logic              primed_q;

  // register idles high like an undriven line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '1;
      primed_q <= 1'b0;
    end else begin
      data_q   <= data_i;
      primed_q <= 1'b1;
    end
  end

  assign data_o = sel_reg_i ? data_q : data_i;

  p_reg_path_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && sel_reg_i) |-> data_o == $past(data_i));
  p_pass_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_reg_i |-> data_o == data_i);
endmodule

// File: rtl/msgch_rx_mux.sv
module msgch_rx_mux #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              loop_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] rx_o,
  output logic              oe_o
);
  assign oe_o = ~loop_i;
  assign rx_o = loop_i ? tx_i : bus_i;
endmodule

// File: rtl/msgch_txpath.sv
module msgch_txpath
  import msgch_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] rx_data_o
);
  msgch_ctrl_t       ctrl;
  logic [DATA_W-1:0] tx_sel;

  msgch_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .ctrl_o  (ctrl)
  );

  msgch_tx_stage #(.DATA_W(DATA_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_reg_i (ctrl.reg_mode),
    .data_i    (tx_data_i),
    .data_o    (tx_sel)
  );

  msgch_rx_mux #(.DATA_W(DATA_W)) u_rx (
    .loop_i (ctrl.loop),
    .tx_i   (tx_sel),
    .bus_i  (bus_data_i),
    .rx_o   (rx_data_o),
    .oe_o   (bus_oe_o)
  );

  assign bus_data_o = tx_sel;

  p_oe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o == !cfg_rdata_o[LOOP_BIT]);
  p_loop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> rx_data_o == bus_data_o);
  p_rx_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> rx_data_o == bus_data_i);
endmodule

// File: tb/msgch_txpath_bench.sv
module msgch_txpath_bench;
  localparam int unsigned W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [W-1:0] tx = '0;
  logic [W-1:0] bus_out;
  logic         oe;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] rx;

  int tests = 0;
  int fails = 0;

  // reference state
  bit         m_mode = 0;
  bit         m_loop = 0;
  bit [W-1:0] m_txq = '1;

  always #2 clk = ~clk;

  msgch_txpath #(.DATA_W(W)) u_msgch_txpath (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .tx_data_i(tx), .bus_data_o(bus_out),
    .bus_oe_o(oe), .bus_data_i(bus_in), .rx_data_o(rx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [W-1:0] e_bus;
    e_bus = m_mode ? m_txq : tx;
    chk(m_mode ? "R3 registered tx" : "R2 pass-through tx", bus_out, e_bus);
    chk("R4 output enable", oe, !m_loop);
    if (m_loop) chk("R5/R8 loopback rx", rx, e_bus);
    else        chk("R6 rx from bus", rx, bus_in);
    chk("R7 readback", rdata, {2'b00, m_loop, m_mode, 4'b0000});
  endtask

  // one cycle: edge updates model, then drive at negedge and compare
  task automatic step(bit nwe, logic [7:0] nwd, logic [W-1:0] ntx, logic [W-1:0] nbus);
    @(posedge clk);
    if (we) begin
      m_loop = wdata[5];
      m_mode = wdata[4];
    end
    m_txq = tx;
    @(negedge clk);
    we = nwe; wdata = nwd; tx = ntx; bus_in = nbus;
    #1;
    compare();
  endtask

  initial begin
    #300000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tx = 4'h5; bus_in = 4'ha;
    #9;
    // R1 reset state
    chk("R1 readback", rdata, 8'h00);
    chk("R1 oe", oe, 1'b1);
    chk("R1 pass-through", bus_out, 4'h5);
    chk("R1 rx from bus", rx, 4'ha);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare();

    // R7: write ignored without strobe
    step(0, 8'hff, 4'h3, 4'hc);
    step(0, 8'h30, 4'h6, 4'h9);
    chk("R7 no write without strobe", rdata, 8'h00);
    // R3: switch to registered at the same edge tx is captured
    step(1, 8'h10, 4'h1, 4'h0);
    step(0, 8'h00, 4'h2, 4'hf);
    step(0, 8'h00, 4'h7, 4'h8);
    // R5/R8: loopback in registered mode, bus input toggling
    step(1, 8'h30, 4'he, 4'h1);
    step(0, 8'h00, 4'hd, 4'he);
    step(0, 8'h00, 4'hd, 4'h0);
    // loopback in pass-through mode, other bits set in write data
    step(1, 8'hef, 4'h4, 4'hb);
    step(0, 8'h00, 4'hb, 4'h4);
    // back to normal
    step(1, 8'h00, 4'h0, 4'h6);
    step(0, 8'h00, 4'h9, 4'h3);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 3) == 0, 8'($urandom), W'($urandom), W'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule